// File: doc/BRIEF.md
# Instruction TLB Recency Tracker

This block keeps the replacement order of a four-way instruction TLB. Instead of one age counter per way it holds a 6-bit pairwise-order code: each bit records which of two ways was used more recently. Every lookup hit or refill touches one way and updates the code. Each way has a fixed set of bits it forces high and a fixed set it forces low, and the bits it does not own keep their value. The way to evict is read back by matching the code against one fixed pattern per way.

Software may overwrite the whole code through a write strobe. The write lands on the next clock edge and takes precedence over a touch in the same cycle. The victim index and an error flag are decoded combinationally from the stored code. The error flag is set when the code matches no way's eviction pattern, which can only happen after software has written an inconsistent value.

Top module: `itlb_lru_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the stored code `lru_state` is 6'b000000, which decodes to victim way 3 with `victim_err` low.
- R2: A touch of way 0 (`touch_vld`=1, `touch_idx`=0, no write) clears bits 5, 4 and 3 on the next edge and leaves bits 2..0 unchanged.
- R3: A touch of way 1 sets bit 5 and clears bits 2 and 1 on the next edge, leaving bits 4, 3 and 0 unchanged.
- R4: A touch of way 2 sets bits 4 and 2 and clears bit 0 on the next edge, leaving bits 5, 3 and 1 unchanged.
- R5: A touch of way 3 sets bits 3, 1 and 0 on the next edge, leaving bits 5, 4 and 2 unchanged.
- R6: The victim is way 0 when bits 5..3 are 111. It is way 1 when bit 5=0 and bits 2..1 are 11. It is way 2 when bit 4=0, bit 2=0 and bit 0=1. It is way 3 when bits 3, 1 and 0 are all 0. The conditions are tested in the order 0, 1, 2, 3.
- R7: When no condition of R6 holds, `victim_err` is 1 and `victim_idx` is 0. Otherwise `victim_err` is 0.
- R8: When `sw_wr_en` is 1, `lru_state` equals `sw_wr_data` after the next edge, even if a touch is presented in the same cycle.
- R9: With neither `touch_vld` nor `sw_wr_en` asserted, `lru_state` holds its value whatever `touch_idx` and `sw_wr_data` carry.
- R10: After a touch of a way without a write, that way is not the reported victim on the next cycle.
- R11: Starting from any consistent code, after all four ways are touched in some order, the victim is the first way of that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| touch_vld | input | 1 | A way was hit or refilled this cycle |
| touch_idx | input | 2 | Index of the touched way |
| sw_wr_en | input | 1 | Software write of the recency code |
| sw_wr_data | input | 6 | Value written by software |
| lru_state | output | 6 | Current pairwise recency code |
| victim_idx | output | 2 | Way to replace on the next refill |
| victim_err | output | 1 | Code matches no way's eviction pattern |

## Verification
A touch and a software write can fall in the same cycle, and the write must win. The bench provokes this by presenting both strobes on one edge, once with a written value the touch would have altered and several times in a pseudo-random phase. The scoreboard expects exactly the written code and the victim decoded from it. An in-design property also checks that any write strobe leaves the written value in the register one cycle later, whatever the touch inputs carry.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
  localparam int unsigned ORD_W    = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [ORD_W-1:0] ord_t;

  // Per-way update patterns, element g belongs to way g.
  localparam ord_t [NUM_WAYS-1:0] TOUCH_SET = {
    6'b001011,   // way 3
    6'b010100,   // way 2
    6'b100000,   // way 1
    6'b000000    // way 0
  };
  localparam ord_t [NUM_WAYS-1:0] TOUCH_CLR = {
    6'b000000,
    6'b000001,
    6'b000110,
    6'b111000
  };

  // Eviction match: (code & care) == value
  localparam ord_t [NUM_WAYS-1:0] EVICT_CARE = {
    6'b001011,
    6'b010101,
    6'b100110,
    6'b111000
  };
  localparam ord_t [NUM_WAYS-1:0] EVICT_VAL = {
    6'b000000,
    6'b000001,
    6'b000110,
    6'b111000
  };
endpackage

// File: rtl/lru_touch_next.sv
module lru_touch_next
  import itlb_lru_pkg::*;
(
  input  ord_t cur_ord,
  input  logic touch_vld,
  input  way_t touch_idx,
  input  logic wr_en,
  input  ord_t wr_data,
  output ord_t nxt_ord,
  output logic upd_en
);
  ord_t cand [NUM_WAYS];

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cand
    assign cand[g] = (cur_ord & ~TOUCH_CLR[g]) | TOUCH_SET[g];
  end

  always_comb begin
    nxt_ord = cur_ord;
    if (touch_vld) begin
      nxt_ord = cand[touch_idx];
    end
    if (wr_en) begin
      nxt_ord = wr_data;
    end
  end

  assign upd_en = touch_vld | wr_en;
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
  import itlb_lru_pkg::*;
(
  input  ord_t ord,
  output way_t victim,
  output logic err
);
  logic [NUM_WAYS-1:0] hit;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_match
    assign hit[g] = ((ord & EVICT_CARE[g]) == EVICT_VAL[g]);
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found && hit[i]) begin
        victim = way_t'(i);
        found  = 1'b1;
      end
    end
    err = !found;
  end

  // R6: the eviction patterns are mutually exclusive
  always_comb begin
    p_evict_exclusive_r6: assert ($onehot0(hit))
      else $error("p_evict_exclusive_r6: several ways match");
  end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
  import itlb_lru_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_vld,
  input  logic [WAY_W-1:0] touch_idx,
  input  logic             sw_wr_en,
  input  logic [ORD_W-1:0] sw_wr_data,
  output logic [ORD_W-1:0] lru_state,
  output logic [WAY_W-1:0] victim_idx,
  output logic             victim_err
);
  logic rst_meta_q;
  logic rst_sync_n;
  ord_t lru_q;
  ord_t lru_d;
  logic lru_en;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lru_touch_next u_next (
    .cur_ord   (lru_q),
    .touch_vld (touch_vld),
    .touch_idx (touch_idx),
    .wr_en     (sw_wr_en),
    .wr_data   (sw_wr_data),
    .nxt_ord   (lru_d),
    .upd_en    (lru_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lru_q <= '0;
    end else if (lru_en) begin
      lru_q <= lru_d;
    end
  end

  lru_victim_sel u_victim (
    .ord    (lru_q),
    .victim (victim_idx),
    .err    (victim_err)
  );

  assign lru_state = lru_q;

  // R2
  p_touch_way0_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    touch_vld && !sw_wr_en && touch_idx == 2'd0 |=>
      lru_q[5:3] == 3'b000 && lru_q[2:0] == $past(lru_q[2:0]));
  // R3
  p_touch_way1_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    touch_vld && !sw_wr_en && touch_idx == 2'd1 |=>
      lru_q[5] && !lru_q[2] && !lru_q[1] &&
      lru_q[4:3] == $past(lru_q[4:3]) && lru_q[0] == $past(lru_q[0]));
  // R4
  p_touch_way2_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    touch_vld && !sw_wr_en && touch_idx == 2'd2 |=>
      lru_q[4] && lru_q[2] && !lru_q[0] &&
      lru_q[5] == $past(lru_q[5]) && lru_q[3] == $past(lru_q[3]) &&
      lru_q[1] == $past(lru_q[1]));
  // R5
  p_touch_way3_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    touch_vld && !sw_wr_en && touch_idx == 2'd3 |=>
      lru_q[3] && lru_q[1] && lru_q[0] &&
      lru_q[5:4] == $past(lru_q[5:4]) && lru_q[2] == $past(lru_q[2]));
  // R8
  p_sw_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_wr_en |=> lru_state == $past(sw_wr_data));
  // R9
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !touch_vld && !sw_wr_en |=> $stable(lru_state));
  // R10
  p_touched_not_victim_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    touch_vld && !sw_wr_en |=> victim_err || victim_idx != $past(touch_idx));
endmodule

// File: tb/itlb_lru_tracker_tb_top.sv
module itlb_lru_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       touch_vld;
  logic [1:0] touch_idx;
  logic       sw_wr_en;
  logic [5:0] sw_wr_data;
  logic [5:0] lru_state;
  logic [1:0] victim_idx;
  logic       victim_err;

  int checks = 0;
  int errors = 0;
  logic [5:0] model = 6'b0;

  logic [5:0] q_st[$];
  logic [1:0] q_vic[$];
  logic       q_err[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  itlb_lru_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .touch_vld(touch_vld), .touch_idx(touch_idx),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .lru_state(lru_state),
    .victim_idx(victim_idx), .victim_err(victim_err)
  );

  function automatic logic [5:0] apply_touch(logic [5:0] s, logic [1:0] w);
    logic [5:0] r;
    r = s;
    case (w)
      2'd0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
      2'd1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
      2'd2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
      default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
    endcase
    return r;
  endfunction

  function automatic logic [2:0] pick(logic [5:0] s); // {err, victim}
    if (s[5] && s[4] && s[3])        return 3'b000;
    if (!s[5] && s[2] && s[1])       return 3'b001;
    if (!s[4] && !s[2] && s[0])      return 3'b010;
    if (!s[3] && !s[1] && !s[0])     return 3'b011;
    return 3'b100;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic tv, logic [1:0] w, logic wr, logic [5:0] d, string tag);
    logic [2:0] pv;
    @(negedge clk);
    touch_vld = tv; touch_idx = w; sw_wr_en = wr; sw_wr_data = d;
    if (wr)      model = d;
    else if (tv) model = apply_touch(model, w);
    pv = pick(model);
    q_st.push_back(model);
    q_vic.push_back(pv[1:0]);
    q_err.push_back(pv[2]);
    q_tag.push_back(tag);
  endtask

  task automatic settle();
    @(negedge clk);
    touch_vld = 0; sw_wr_en = 0;
  endtask

  // Monitor: compare results right after each edge
  always @(posedge clk) begin
    #1;
    if (q_st.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk({t, " state"},  lru_state,  q_st.pop_front());
      chk({t, " victim"}, victim_idx, q_vic.pop_front());
      chk({t, " err"},    victim_err, q_err.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 0; touch_vld = 0; touch_idx = 0; sw_wr_en = 0; sw_wr_data = 0;
    repeat (3) @(posedge clk);
    chk("R1 state in reset", lru_state, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 state", lru_state, 0);
    chk("R1 victim", victim_idx, 3);
    chk("R1 err", victim_err, 0);

    drive(1, 1, 0, 0, "R3");
    drive(1, 2, 0, 0, "R4");
    drive(1, 3, 0, 0, "R5");
    drive(1, 0, 0, 0, "R2");
    drive(0, 2, 0, 6'h2a, "R9");
    drive(0, 1, 0, 6'h15, "R9");

    // R11: the first way of a full touch order becomes the victim
    drive(1, 0, 0, 0, "R11"); drive(1, 1, 0, 0, "R11");
    drive(1, 2, 0, 0, "R11"); drive(1, 3, 0, 0, "R11");
    settle(); chk("R11 order 0123", victim_idx, 0);
    drive(1, 2, 0, 0, "R11"); drive(1, 0, 0, 0, "R11");
    drive(1, 3, 0, 0, "R11"); drive(1, 1, 0, 0, "R11");
    settle(); chk("R11 order 2031", victim_idx, 2);

    // R10
    for (int k = 0; k < 4; k++) begin
      drive(1, 2'(k), 0, 0, "R10");
      settle();
      checks++;
      if (!victim_err && victim_idx == 2'(k)) begin
        errors++;
        $display("FAIL R10: actual victim %0d expected not %0d", victim_idx, k);
      end
    end

    // R6 and R7 through software writes
    drive(0, 0, 1, 6'b111000, "R6");
    drive(0, 0, 1, 6'b111111, "R6");
    drive(0, 0, 1, 6'b000110, "R6");
    drive(0, 0, 1, 6'b010111, "R6");
    drive(0, 0, 1, 6'b000001, "R6");
    drive(0, 0, 1, 6'b101001, "R6");
    drive(0, 0, 1, 6'b000000, "R6");
    drive(0, 0, 1, 6'b011011, "R7");
    settle();
    chk("R7 err", victim_err, 1);
    chk("R7 victim", victim_idx, 0);
    drive(1, 0, 0, 0, "R2 from bad code");

    // R8: write collides with touch
    drive(1, 3, 1, 6'b000000, "R8");
    drive(1, 1, 1, 6'b000110, "R8");
    settle();
    chk("R8 collide", lru_state, 6'b000110);

    lfsr = 8'h5d;
    for (int n = 0; n < 300; n++) begin
      logic tv, wr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tv = lfsr[0] | lfsr[3];
      wr = (lfsr[7:5] == 3'b101);
      drive(tv, lfsr[2:1], wr, {lfsr[6:4], lfsr[2:0]},
            wr ? "R8 mix" : (tv ? "R6 mix" : "R9 mix"));
    end
    settle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule